// File: doc/BRIEF.md
# NAND Flash Page Access Sequencer

This block sits between a host and an 8-bit NAND flash device. It performs one whole-page program or one whole-page read per start pulse. It drives the command and address cycles on the flash bus, moves the page bytes between the flash and two byte-wide valid/ready streams on the host side, and waits on the device's ready/busy line. During the slow per-byte data phases, chip enable is released between transfers to save power. When chip enable comes back low, the block adds a setup margin before a write strobe, or an access margin before it samples read data. Chip enable stays low for the whole internal array-read busy time.

The controller is a single state machine. Its states are:

- Idle: waits for a start pulse.
- Command strobe and command hold.
- Address strobe and address hold, repeated once per address byte.
- Data-in wait (chip enable high, asking the host for a byte), data-in setup (chip enable low), data-in strobe and data-in hold.
- Busy lead-in, then busy.
- Read strobe, then read wait (chip enable high, offering the byte to the host).
- Done.

The transitions are:

- Idle → command, on start.
- Command hold → address, for the first command of an operation.
- Command hold → busy lead-in, after the confirm command.
- Address hold → address, until the last address byte.
- After the last address byte:
  - on a read, address hold → busy lead-in;
  - on a program, address hold → data-in wait.
- Data-in wait → data-in setup, on host valid.
- Data-in hold → data-in wait, before the last byte.
- Data-in hold → command, on the last byte, which issues the confirm.
- Busy lead-in → busy, after the busy lead-in time.
- Busy → read strobe (read) or busy → done (program), once ready is seen.
- Read strobe → read wait.
- Read wait → read strobe, on host ready, before the last byte.
- Read wait → done, on host ready for the last byte.
- Done → idle.

All intervals are whole system-clock cycles set by parameters.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, chip enable (active low) is high. The command latch, address latch and done outputs are low. Write and read strobes (active low) are high. wr_ready and rd_valid are low.
- R2: A program (op_read=0) puts these bytes on the bus, each latched on a rising write strobe:
  - the command 80h, with the command latch high;
  - the three start-address bytes, least significant byte first, with the address latch high;
  - XFER_BYTES data bytes, in the order the host supplied them, with both latches low;
  - the confirm command 10h.
  The command latch and the address latch are never high together.
- R3: A read (op_read=1) issues the command 00h and then the three address bytes, least significant first. After busy, it delivers XFER_BYTES bytes from the flash on rd_data in order. rd_valid and rd_data hold steady while rd_ready is low.
- R4: In the data-load phase, chip enable goes high between the host byte request and every data write strobe, including the first.
- R5: Chip enable is low for at least TCS_CYC cycles before each data write strobe falls.
- R6: In a read, chip enable goes high between consecutive read strobes. Each read strobe and the chip-enable low time before sampling both last at least max(TCEA_CYC, TREA_CYC) cycles.
- R7: Chip enable stays low for the whole busy interval after the read address cycles.
- R8: The block reads data and pulses done only after the synchronized ready/busy input has returned to ready.
- R9: A start pulse received while an operation is in progress is ignored.
- R10: The block drives the I/O byte only in command, address and data-input cycles, and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_read | input | 1 | 1 = page read, 0 = page program; sampled with start |
| start_addr | input | ADDR_W | Start address, sent least significant byte first |
| wr_data | input | 8 | Program data byte from the host |
| wr_valid | input | 1 | wr_data is valid |
| wr_ready | output | 1 | Block accepts wr_data this cycle |
| rd_data | output | 8 | Read data byte to the host |
| rd_valid | output | 1 | rd_data is valid |
| rd_ready | input | 1 | Host accepts rd_data this cycle |
| done | output | 1 | One-cycle pulse when the operation completes |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_io | inout | 8 | Flash bidirectional data bus |
| fl_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest situations to reach from the ports are these:

- chip-enable margins at the point where chip enable returns low after a gap;
- a start pulse that lands in the middle of a long data stream.

The bench includes a cycle-sampling flash model that logs every latched byte and counts chip-enable gaps and low-time runs before each strobe. It also holds ready/busy low for a fixed time and notes any chip-enable release or read strobe during that window. One program run fires a second start with the opposite operation partway through the page. One read run withholds rd_ready for several cycles at intervals to exercise the hold behaviour.

// File: rtl/nps_pkg.sv
package nps_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_CMD_HOLD, S_ADDR, S_ADDR_HOLD,
        S_DIN_WAIT, S_DIN_CS, S_DIN_WE, S_DIN_HOLD,
        S_BUSY_WB, S_BUSY, S_DOUT_RE, S_DOUT_WAIT, S_DONE
    } nps_state_e;

    localparam logic [7:0] OPC_READ    = 8'h00;
    localparam logic [7:0] OPC_PROG    = 8'h80;
    localparam logic [7:0] OPC_CONFIRM = 8'h10;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/nps_rb_sync.sv
module nps_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic rb_ready
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], rb_n_async};
    end

    assign rb_ready = sync_q[STAGES-1];
endmodule

// File: rtl/nps_timer.sv
module nps_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
    import nps_pkg::*;
#(
    parameter int XFER_BYTES  = 528,
    parameter int ADDR_CYCLES = 3,
    parameter int ADDR_W      = 8 * ADDR_CYCLES,
    parameter int TCS_CYC     = 1,
    parameter int TWP_CYC     = 2,
    parameter int TWH_CYC     = 1,
    parameter int TCEA_CYC    = 3,
    parameter int TREA_CYC    = 2,
    parameter int TWB_CYC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_read,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              done,
    output logic              fl_ce_n,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_we_n,
    output logic              fl_re_n,
    inout  wire  [7:0]        fl_io,
    input  logic              fl_rb_n
);
    localparam int RD_CYC = imax(TCEA_CYC, TREA_CYC);
    localparam int TMAX   = imax(imax(imax(TCS_CYC, TWP_CYC), imax(TWH_CYC, TWB_CYC)), RD_CYC);
    localparam int TMR_W  = $clog2(TMAX + 1);
    localparam int CNT_W  = $clog2(XFER_BYTES + 1);
    localparam int ACNT_W = $clog2(ADDR_CYCLES + 1);

    nps_state_e        state_q, state_d;
    logic              op_rd_q;
    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ACNT_W-1:0] acnt_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [7:0]        dbuf_q;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              rb_ready;
    logic              io_oe;
    logic [7:0]        io_out;
    logic              last_byte, last_addr;

    assign last_byte = (bcnt_q == CNT_W'(XFER_BYTES - 1));
    assign last_addr = (acnt_q == ACNT_W'(ADDR_CYCLES - 1));

    nps_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rb_n_async(fl_rb_n), .rb_ready(rb_ready)
    );

    nps_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    // next state and interval loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_CMD; tmr_load = 1'b1; tmr_val = TMR_W'(TWP_CYC - 1);
            end
            S_CMD: if (tmr_zero) begin
                state_d = S_CMD_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(TWH_CYC - 1);
            end
            S_CMD_HOLD: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (cmd_q == OPC_CONFIRM) begin
                    state_d = S_BUSY_WB; tmr_val = TMR_W'(TWB_CYC - 1);
                end else begin
                    state_d = S_ADDR; tmr_val = TMR_W'(TWP_CYC - 1);
                end
            end
            S_ADDR: if (tmr_zero) begin
                state_d = S_ADDR_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(TWH_CYC - 1);
            end
            S_ADDR_HOLD: if (tmr_zero) begin
                if (!last_addr) begin
                    state_d = S_ADDR; tmr_load = 1'b1; tmr_val = TMR_W'(TWP_CYC - 1);
                end else if (op_rd_q) begin
                    state_d = S_BUSY_WB; tmr_load = 1'b1; tmr_val = TMR_W'(TWB_CYC - 1);
                end else begin
                    state_d = S_DIN_WAIT;
                end
            end
            S_DIN_WAIT: if (wr_valid) begin
                state_d = S_DIN_CS; tmr_load = 1'b1; tmr_val = TMR_W'(TCS_CYC - 1);
            end
            S_DIN_CS: if (tmr_zero) begin
                state_d = S_DIN_WE; tmr_load = 1'b1; tmr_val = TMR_W'(TWP_CYC - 1);
            end
            S_DIN_WE: if (tmr_zero) begin
                state_d = S_DIN_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(TWH_CYC - 1);
            end
            S_DIN_HOLD: if (tmr_zero) begin
                if (last_byte) begin
                    state_d = S_CMD; tmr_load = 1'b1; tmr_val = TMR_W'(TWP_CYC - 1);
                end else begin
                    state_d = S_DIN_WAIT;
                end
            end
            S_BUSY_WB: if (tmr_zero) state_d = S_BUSY;
            S_BUSY: if (rb_ready) begin
                if (op_rd_q) begin
                    state_d = S_DOUT_RE; tmr_load = 1'b1; tmr_val = TMR_W'(RD_CYC - 1);
                end else begin
                    state_d = S_DONE;
                end
            end
            S_DOUT_RE: if (tmr_zero) state_d = S_DOUT_WAIT;
            S_DOUT_WAIT: if (rd_ready) begin
                if (last_byte) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_DOUT_RE; tmr_load = 1'b1; tmr_val = TMR_W'(RD_CYC - 1);
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_rd_q <= 1'b0;
            cmd_q   <= '0;
            addr_q  <= '0;
            acnt_q  <= '0;
            bcnt_q  <= '0;
            dbuf_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                op_rd_q <= op_read;
                cmd_q   <= op_read ? OPC_READ : OPC_PROG;
                addr_q  <= start_addr;
                acnt_q  <= '0;
                bcnt_q  <= '0;
            end
            if (state_q == S_ADDR_HOLD && tmr_zero) begin
                addr_q <= addr_q >> 8;
                acnt_q <= acnt_q + 1'b1;
            end
            if (state_q == S_DIN_WAIT && wr_valid) dbuf_q <= wr_data;
            if (state_q == S_DIN_HOLD && tmr_zero) begin
                bcnt_q <= bcnt_q + 1'b1;
                if (last_byte) cmd_q <= OPC_CONFIRM;
            end
            if (state_q == S_DOUT_RE && tmr_zero) dbuf_q <= fl_io;
            if (state_q == S_DOUT_WAIT && rd_ready) bcnt_q <= bcnt_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        fl_ce_n  = 1'b1;
        fl_cle   = 1'b0;
        fl_ale   = 1'b0;
        fl_we_n  = 1'b1;
        fl_re_n  = 1'b1;
        io_oe    = 1'b0;
        io_out   = 8'h00;
        wr_ready = 1'b0;
        rd_valid = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_CMD, S_CMD_HOLD: begin
                fl_ce_n = 1'b0; fl_cle = 1'b1; io_oe = 1'b1; io_out = cmd_q;
                fl_we_n = (state_q != S_CMD);
            end
            S_ADDR, S_ADDR_HOLD: begin
                fl_ce_n = 1'b0; fl_ale = 1'b1; io_oe = 1'b1; io_out = addr_q[7:0];
                fl_we_n = (state_q != S_ADDR);
            end
            S_DIN_WAIT: wr_ready = 1'b1;
            S_DIN_CS, S_DIN_WE, S_DIN_HOLD: begin
                fl_ce_n = 1'b0; io_oe = 1'b1; io_out = dbuf_q;
                fl_we_n = (state_q != S_DIN_WE);
            end
            S_BUSY_WB, S_BUSY: fl_ce_n = 1'b0;
            S_DOUT_RE: begin
                fl_ce_n = 1'b0; fl_re_n = 1'b0;
            end
            S_DOUT_WAIT: rd_valid = 1'b1;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign fl_io   = io_oe ? io_out : 8'hzz;
    assign rd_data = dbuf_q;

    AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_we_n) && !fl_cle && !fl_ale) |-> $past(!fl_ce_n)) else $error("tCS"); // R5
    AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> fl_ce_n) else $error("gap"); // R4
    AST_BUSY_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rd_q && (state_q == S_BUSY_WB || state_q == S_BUSY)) |-> !fl_ce_n) else $error("busy ce"); // R7
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rb_ready)) else $error("done early"); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> !io_oe) else $error("contention"); // R10
    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))) else $error("rd hold"); // R3
endmodule

// File: tb/sim_nand_page_seq.sv
module sim_nand_page_seq;
    localparam int N        = 528;
    localparam int TCS      = 1;
    localparam int RDC      = 3;
    localparam int BUSY_CYC = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start, op_read, wr_valid, rd_ready;
    logic [23:0] start_addr;
    logic [7:0]  wr_data, rd_data;
    logic        wr_ready, rd_valid, done;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n;
    wire  [7:0]  fl_io;
    logic        rb;

    int checks = 0, failures = 0;

    nand_page_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read), .start_addr(start_addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done),
        .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
        .fl_re_n(fl_re_n), .fl_io(fl_io), .fl_rb_n(rb)
    );

    function automatic logic [7:0] rpat(input int i);
        return 8'((i * 5 + 60) ^ (i >> 8));
    endfunction
    function automatic logic [7:0] wpat(input int i, input int seed);
        return 8'((i * 7 + seed) ^ (i >> 8));
    endfunction

    // flash model, sampled on falling clock edges
    int          cyc = 0, rd_idx = 0, cmd_n = 0, addr_n = 0, din_n = 0;
    logic [7:0]  cmd_log [0:7];
    logic [7:0]  addr_b [0:3];
    logic [7:0]  din [0:N-1];
    int          din_gap = 0, rd_gap = 0, tcs_bad = 0, tcea_bad = 0, busy_ce_hi = 0;
    int          re_in_busy = 0, latch_clash = 0, busy_left = 0, rb_rise_cyc = 0;
    int          ce_lo_cnt = 0, last_ce_lo = 0, done_cnt = 0, done_cyc = 0;
    logic        ce_hi_seen = 1'b0, prev_we = 1'b1, prev_re = 1'b1, rd_mode = 1'b0;

    assign fl_io = (!fl_ce_n && !fl_re_n) ? rpat(rd_idx) : 8'hzz;

    always @(negedge clk) begin
        cyc++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (!rst_n) begin
            rb = 1'b1; busy_left = 0; prev_we = 1'b1; prev_re = 1'b1;
        end else begin
            if (fl_cle && fl_ale) latch_clash++;
            if (prev_we && !fl_we_n && !fl_cle && !fl_ale) begin
                if (ce_lo_cnt < TCS) tcs_bad++;
                if (ce_hi_seen) din_gap++;
                ce_hi_seen = 1'b0;
            end
            if (!prev_we && fl_we_n && !fl_ce_n) begin
                if (fl_cle) begin
                    if (fl_io == 8'h80 || fl_io == 8'h00) begin
                        cmd_n = 0; addr_n = 0; din_n = 0; rd_idx = 0; din_gap = 0; rd_gap = 0;
                        tcs_bad = 0; tcea_bad = 0; busy_ce_hi = 0; re_in_busy = 0;
                        ce_hi_seen = 1'b0; rd_mode = (fl_io == 8'h00);
                    end
                    if (cmd_n < 8) cmd_log[cmd_n] = fl_io;
                    cmd_n++;
                    if (fl_io == 8'h10) busy_left = BUSY_CYC;
                end else if (fl_ale) begin
                    if (addr_n < 4) addr_b[addr_n] = fl_io;
                    addr_n++;
                    if (addr_n == 3 && rd_mode) busy_left = BUSY_CYC;
                end else begin
                    if (din_n < N) din[din_n] = fl_io;
                    din_n++;
                end
            end
            if (prev_re && !fl_re_n) begin
                if (!rb) re_in_busy++;
                if (ce_hi_seen) rd_gap++;
                ce_hi_seen = 1'b0;
            end
            if (!fl_re_n) last_ce_lo = ce_lo_cnt + 1;
            if (!prev_re && fl_re_n) begin
                if (last_ce_lo < RDC) tcea_bad++;
                rd_idx++;
            end
            if (busy_left > 0) begin
                rb = 1'b0; busy_left--;
                if (fl_ce_n && rd_mode) busy_ce_hi++;
            end else if (!rb) begin
                rb = 1'b1; rb_rise_cyc = cyc;
            end
            prev_we = fl_we_n;
            prev_re = fl_re_n;
        end
        if (fl_ce_n) begin ce_hi_seen = 1'b1; ce_lo_cnt = 0; end
        else ce_lo_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic rd, input logic [23:0] a);
        op_read = rd; start_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk("R8 done seen", 32'(done), 32'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; op_read = 1'b0; start_addr = '0;
        wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ce_n", 32'(fl_ce_n), 32'd1);
        chk("R1 cle/ale", {30'd0, fl_cle, fl_ale}, 32'd0);
        chk("R1 we_n/re_n", {30'd0, fl_we_n, fl_re_n}, 32'd3);
        chk("R1 done/wr_ready/rd_valid", {29'd0, done, wr_ready, rd_valid}, 32'd0);
    endtask

    task automatic t_program(input logic [23:0] a, input int seed, input bit inject);
        int bad = 0, d0 = done_cnt;
        pulse_start(1'b0, a);
        fork
            begin
                for (int i = 0; i < N; i++) begin
                    wr_data = wpat(i, seed); wr_valid = 1'b1;
                    while (!wr_ready) @(negedge clk);
                    @(negedge clk);
                    wr_valid = 1'b0;
                end
            end
            begin
                if (inject) begin
                    repeat (300) @(negedge clk);
                    pulse_start(1'b1, 24'hFFFFFF);  // R9: must be ignored
                end
                wait_done();
            end
        join
        for (int i = 0; i < N; i++) if (din[i] !== wpat(i, seed)) bad++;
        chk("R2 command count", 32'(cmd_n), 32'd2);
        chk("R2 first command 80h", 32'(cmd_log[0]), 32'h80);
        chk("R2 confirm 10h", 32'(cmd_log[1]), 32'h10);
        chk("R2 address LSB first", {8'd0, addr_b[2], addr_b[1], addr_b[0]}, {8'd0, a});
        chk("R2 data byte count", 32'(din_n), 32'(N));
        chk("R2 data mismatches", 32'(bad), 32'd0);
        chk("R2 latch exclusivity", 32'(latch_clash), 32'd0);
        chk("R4 ce gaps before data strobes", 32'(din_gap), 32'(N));
        chk("R5 tCS violations", 32'(tcs_bad), 32'd0);
        chk("R8 done after ready", 32'(done_cyc > rb_rise_cyc), 32'd1);
        chk("R9 one done per op", 32'(done_cnt - d0), 32'd1);
    endtask

    task automatic t_read(input logic [23:0] a, input bit stall);
        int bad = 0, moved = 0, d0 = done_cnt;
        logic [7:0] held;
        pulse_start(1'b1, a);
        for (int i = 0; i < N; i++) begin
            int n = 0;
            while (!rd_valid && n < 20000) begin @(negedge clk); n++; end
            if (stall && (i % 37 == 0)) begin
                held = rd_data;
                repeat (4) begin
                    @(negedge clk);
                    if (!rd_valid || rd_data !== held) moved++;
                end
            end
            if (rd_data !== rpat(i)) bad++;
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
        wait_done();
        chk("R3 command 00h only", {cmd_n[23:0], cmd_log[0]}, {24'd1, 8'h00});
        chk("R3 address LSB first", {8'd0, addr_b[2], addr_b[1], addr_b[0]}, {8'd0, a});
        chk("R3 R10 read data mismatches", 32'(bad), 32'd0);
        chk("R3 rd hold under backpressure", 32'(moved), 32'd0);
        chk("R6 ce gaps between read strobes", 32'(rd_gap), 32'(N - 1));
        chk("R6 tCEA/tREA violations", 32'(tcea_bad), 32'd0);
        chk("R7 ce high during busy", 32'(busy_ce_hi), 32'd0);
        chk("R8 read strobe during busy", 32'(re_in_busy), 32'd0);
        chk("R8 one done per read", 32'(done_cnt - d0), 32'd1);
    endtask

    initial begin
        t_reset();
        t_program(24'h12A5C3, 1, 1'b0);
        t_read(24'h004321, 1'b0);
        t_program(24'hF0E1D2, 9, 1'b1);
        t_read(24'hABCDEF, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end
endmodule